// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the control half of a successive-approximation converter. It decides which analog channel is sampled next, hands that channel and a one-cycle start pulse to the converter, and files each 12-bit result once the converter reports done. There are two channel lists. The regular list has up to 16 slots and leaves all of its results in one shared data register. The injected list has up to 4 slots, and each slot keeps its own result register. Both lists may name any of 18 channels, with any ordering and any repeats. Channels 0 to 15 are external inputs. Channel 16 is the temperature sensor and channel 17 is the internal reference.

Each list has a length field that holds one less than its slot count. Four modes shape the regular list. In scan mode the sequencer walks through the slots. In single mode it converts only slot 0. In continuous mode it restarts the list after the last slot. In discontinuous mode each trigger converts only a short chunk of slots. A trigger for either list can come from a software strobe, or from a hardware strobe when that strobe is enabled. An injected request takes priority over regular work: it waits for the conversion in progress to finish, runs its whole list, and then hands control back to the regular list at its next slot. Each result is placed right-aligned or left-aligned in a 16-bit word. Separate sticky flags report regular and injected completions.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, conv_start is 0, reg_data and every inj_data slot are 0, and reg_eoc and inj_eoc are 0.
- R2: With scan_en=0, a regular trigger converts the channel in regular slot 0 exactly once and then goes idle. Slot k of a channel table occupies bits [5k+4:5k].
- R3: With scan_en=1, cont_en=0 and disc_en=0, a regular trigger converts slots 0 to reg_len in ascending order (reg_len+1 conversions) and then stops.
- R4: With scan_en=1 and cont_en=1, slot 0 follows the last slot with no new trigger. After cont_en is cleared, the list runs to its last slot and stops there.
- R5: With disc_en=1, each regular trigger converts disc_chunk+1 slots, or fewer if the list ends first. The next trigger resumes at the following slot, and the list wraps to slot 0 after its last slot. cont_en has no effect in this mode.
- R6: An injected trigger converts injected slots 0 to inj_len in order. The result of slot k goes to inj_data bits [16k+15:16k], and slots beyond inj_len keep their contents.
- R7: conv_start is high for exactly one cycle per conversion. conv_chan changes only together with conv_start and carries the programmed channel number (0 to 17) unaltered.
- R8: An injected trigger that arrives during a regular conversion takes effect after that conversion completes. The whole injected list runs next, and regular conversion then resumes at the next regular slot. reg_data is not changed by injected results.
- R9: With align_left=0 a result occupies data bits [11:0] and bits [15:12] are zero. With align_left=1 it occupies bits [15:4] and bits [3:0] are zero. Data registers change only when conv_done is high.
- R10: reg_eoc is set when a regular conversion completes, and inj_eoc is set when the last injected slot completes. Both stay set until their clear input is pulsed. A set in the same cycle as a clear wins.
- R11: The software strobe always triggers its list. The hardware strobe triggers only while its enable is 1. A trigger for a list that is already pending or running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_chan_tbl | input | 80 | Regular channel table, 5 bits per slot |
| reg_len | input | 4 | Regular slot count minus one |
| inj_chan_tbl | input | 20 | Injected channel table, 5 bits per slot |
| inj_len | input | 2 | Injected slot count minus one |
| scan_en | input | 1 | Walk through the regular slots |
| cont_en | input | 1 | Restart the regular list after its end |
| disc_en | input | 1 | Chunked regular conversion |
| disc_chunk | input | 3 | Chunk size minus one |
| align_left | input | 1 | Left-align results |
| reg_sw_start | input | 1 | Software regular trigger |
| reg_hw_trig | input | 1 | Hardware regular trigger |
| reg_hw_en | input | 1 | Enable for the hardware regular trigger |
| inj_sw_start | input | 1 | Software injected trigger |
| inj_hw_trig | input | 1 | Hardware injected trigger |
| inj_hw_en | input | 1 | Enable for the hardware injected trigger |
| reg_eoc_clr | input | 1 | Clear reg_eoc |
| inj_eoc_clr | input | 1 | Clear inj_eoc |
| conv_start | output | 1 | Start-of-conversion pulse |
| conv_chan | output | 5 | Channel to sample |
| conv_done | input | 1 | Converter result valid |
| conv_result | input | 12 | Converter result |
| reg_data | output | 16 | Regular data register |
| inj_data | output | 64 | Injected data registers, 16 bits per slot |
| reg_eoc | output | 1 | Regular completion flag |
| inj_eoc | output | 1 | Injected list completion flag |

## Verification
The bench logs the channel of every start pulse and compares that log with the order the requirements predict.

Several corner cases are covered:
- An injected request placed in the middle of a regular conversion must produce the log 0,15,1,2,3. A design that preempts at once, or that resumes at the wrong slot, produces a duplicated or missing channel.
- Discontinuous chunks must resume where they stopped and wrap after the last slot. An off-by-one in the chunk counter shows up as chunks that are too long.
- Continuous mode must stop on the last slot once cont_en drops.
- The bench retriggers a list while it runs and pulses the hardware strobe with its enable low. It also checks the zero nibble that each alignment leaves and that an unused injected slot keeps its contents.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REG  = 2'd1,
      ST_INJ  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/adc_slot_mux.sv
module adc_slot_mux #(
   parameter int SLOTS = 16,
   parameter int CH_W  = 5,
   parameter int IDX_W = $clog2(SLOTS)
) (
   input  logic [SLOTS*CH_W-1:0] table_i,
   input  logic [IDX_W-1:0]      idx,
   output logic [CH_W-1:0]       chan
);
   assign chan = table_i[idx*CH_W +: CH_W];
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
   parameter int RES_W  = 12,
   parameter int DATA_W = 16
) (
   input  logic [RES_W-1:0]  raw,
   input  logic              left,
   output logic [DATA_W-1:0] word
);
   localparam int PAD = DATA_W - RES_W;

   generate
      if (PAD == 0) begin : g_nopad
         logic unused_left;
         assign unused_left = left;
         assign word = raw;
      end else begin : g_pad
         assign word = left ? {raw, {PAD{1'b0}}} : {{PAD{1'b0}}, raw};
      end
   endgenerate
endmodule

// File: rtl/adc_inj_bank.sv
module adc_inj_bank #(
   parameter int SLOTS  = 4,
   parameter int DATA_W = 16,
   parameter int IDX_W  = $clog2(SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [DATA_W-1:0]       wr_word,
   output logic [SLOTS*DATA_W-1:0] bank_o
);
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(s)))
               word_q <= wr_word;
         end
         assign bank_o[s*DATA_W +: DATA_W] = word_q;
      end
   endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int REG_SLOTS = 16,
   parameter int INJ_SLOTS = 4,
   parameter int CH_W      = 5,
   parameter int RES_W     = 12,
   parameter int DATA_W    = 16,
   parameter int CHUNK_W   = 3,
   localparam int REG_IDX_W = $clog2(REG_SLOTS),
   localparam int INJ_IDX_W = $clog2(INJ_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [REG_SLOTS*CH_W-1:0]   reg_chan_tbl,
   input  logic [REG_IDX_W-1:0]        reg_len,
   input  logic [INJ_SLOTS*CH_W-1:0]   inj_chan_tbl,
   input  logic [INJ_IDX_W-1:0]        inj_len,
   input  logic                        scan_en,
   input  logic                        cont_en,
   input  logic                        disc_en,
   input  logic [CHUNK_W-1:0]          disc_chunk,
   input  logic                        align_left,
   input  logic                        reg_sw_start,
   input  logic                        reg_hw_trig,
   input  logic                        reg_hw_en,
   input  logic                        inj_sw_start,
   input  logic                        inj_hw_trig,
   input  logic                        inj_hw_en,
   input  logic                        reg_eoc_clr,
   input  logic                        inj_eoc_clr,
   output logic                        conv_start,
   output logic [CH_W-1:0]             conv_chan,
   input  logic                        conv_done,
   input  logic [RES_W-1:0]            conv_result,
   output logic [DATA_W-1:0]           reg_data,
   output logic [INJ_SLOTS*DATA_W-1:0] inj_data,
   output logic                        reg_eoc,
   output logic                        inj_eoc
);
   // elaboration-time parameter checks
   if (DATA_W < RES_W) begin : g_bad_width
      $error("DATA_W must be at least RES_W");
   end
   if ((REG_SLOTS < 2) || (REG_SLOTS != (1 << REG_IDX_W))) begin : g_bad_reg
      $error("REG_SLOTS must be a power of two, at least 2");
   end
   if ((INJ_SLOTS < 2) || (INJ_SLOTS != (1 << INJ_IDX_W))) begin : g_bad_inj
      $error("INJ_SLOTS must be a power of two, at least 2");
   end

   seq_state_e             state_q;
   logic [REG_IDX_W-1:0]   reg_slot_q;
   logic [INJ_IDX_W-1:0]   inj_slot_q;
   logic [CHUNK_W-1:0]     chunk_q;
   logic                   reg_run_q, inj_pend_q;
   logic                   start_q, reg_eoc_q, inj_eoc_q;
   logic [CH_W-1:0]        chan_q;
   logic [DATA_W-1:0]      reg_data_q;
   logic [CH_W-1:0]        reg_ch, inj_ch;
   logic [DATA_W-1:0]      fmt_word;
   logic                   reg_fire, inj_fire;
   logic                   reg_last, chunk_end, inj_last, inj_wr;

   adc_slot_mux #(.SLOTS(REG_SLOTS), .CH_W(CH_W)) u_reg_mux (
      .table_i(reg_chan_tbl), .idx(reg_slot_q), .chan(reg_ch));

   adc_slot_mux #(.SLOTS(INJ_SLOTS), .CH_W(CH_W)) u_inj_mux (
      .table_i(inj_chan_tbl), .idx(inj_slot_q), .chan(inj_ch));

   adc_result_fmt #(.RES_W(RES_W), .DATA_W(DATA_W)) u_fmt (
      .raw(conv_result), .left(align_left), .word(fmt_word));

   adc_inj_bank #(.SLOTS(INJ_SLOTS), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(inj_wr), .wr_idx(inj_slot_q),
      .wr_word(fmt_word), .bank_o(inj_data));

   always_comb begin
      reg_fire  = reg_sw_start | (reg_hw_en & reg_hw_trig);
      inj_fire  = inj_sw_start | (inj_hw_en & inj_hw_trig);
      reg_last  = !scan_en || (reg_slot_q >= reg_len);
      chunk_end = (chunk_q == disc_chunk);
      inj_last  = (inj_slot_q >= inj_len);
      inj_wr    = (state_q == ST_INJ) && conv_done;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         reg_slot_q <= '0;
         inj_slot_q <= '0;
         chunk_q    <= '0;
         reg_run_q  <= 1'b0;
         inj_pend_q <= 1'b0;
         start_q    <= 1'b0;
         chan_q     <= '0;
         reg_data_q <= '0;
         reg_eoc_q  <= 1'b0;
         inj_eoc_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (reg_eoc_clr) reg_eoc_q <= 1'b0;
         if (inj_eoc_clr) inj_eoc_q <= 1'b0;
         if (inj_fire && !inj_pend_q) inj_pend_q <= 1'b1;
         if (reg_fire && !reg_run_q) begin
            reg_run_q <= 1'b1;
            chunk_q   <= '0;
         end
         case (state_q)
            ST_IDLE: begin
               if (inj_pend_q) begin
                  state_q <= ST_INJ;
                  start_q <= 1'b1;
                  chan_q  <= inj_ch;
               end else if (reg_run_q) begin
                  state_q <= ST_REG;
                  start_q <= 1'b1;
                  chan_q  <= reg_ch;
               end
            end
            ST_REG: begin
               if (conv_done) begin
                  state_q    <= ST_IDLE;
                  reg_data_q <= fmt_word;
                  reg_eoc_q  <= 1'b1;
                  reg_slot_q <= reg_last ? '0 : reg_slot_q + 1'b1;
                  if (disc_en) begin
                     if (reg_last || chunk_end) begin
                        reg_run_q <= 1'b0;
                        chunk_q   <= '0;
                     end else begin
                        chunk_q <= chunk_q + 1'b1;
                     end
                  end else if (reg_last && !cont_en) begin
                     reg_run_q <= 1'b0;
                  end
               end
            end
            ST_INJ: begin
               if (conv_done) begin
                  state_q <= ST_IDLE;
                  if (inj_last) begin
                     inj_slot_q <= '0;
                     inj_pend_q <= 1'b0;
                     inj_eoc_q  <= 1'b1;
                  end else begin
                     inj_slot_q <= inj_slot_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign conv_start = start_q;
   assign conv_chan  = chan_q;
   assign reg_data   = reg_data_q;
   assign reg_eoc    = reg_eoc_q;
   assign inj_eoc    = inj_eoc_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int CH_W      = 5,
   parameter int DATA_W    = 16,
   parameter int INJ_SLOTS = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        conv_start,
   input logic [CH_W-1:0]             conv_chan,
   input logic                        conv_done,
   input logic [DATA_W-1:0]           reg_data,
   input logic [INJ_SLOTS*DATA_W-1:0] inj_data,
   input logic                        reg_eoc,
   input logic                        inj_eoc,
   input logic                        reg_eoc_clr,
   input logic                        inj_eoc_clr
);
   a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   a_r7_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_start |-> $stable(conv_chan));

   a_r9_reg_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(reg_data));

   a_r9_inj_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(inj_data));

   a_r10_reg_eoc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_eoc) |-> $past(conv_done));

   a_r10_inj_eoc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inj_eoc) |-> $past(conv_done));

   a_r10_reg_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_eoc_clr && !conv_done) |=> !reg_eoc);

   a_r10_inj_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_eoc_clr && !conv_done) |=> !inj_eoc);
endmodule

bind adc_seq_ctrl adc_seq_chk #(
   .CH_W(CH_W), .DATA_W(DATA_W), .INJ_SLOTS(INJ_SLOTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
   .conv_done(conv_done), .reg_data(reg_data), .inj_data(inj_data),
   .reg_eoc(reg_eoc), .inj_eoc(inj_eoc), .reg_eoc_clr(reg_eoc_clr),
   .inj_eoc_clr(inj_eoc_clr)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
   localparam int LAT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [79:0] reg_tbl = '0;
   logic [3:0]  reg_len = '0;
   logic [19:0] inj_tbl = '0;
   logic [1:0]  inj_len = '0;
   logic        scan_en = 0, cont_en = 0, disc_en = 0, align_left = 0;
   logic [2:0]  disc_chunk = '0;
   logic        reg_sw_start = 0, reg_hw_trig = 0, reg_hw_en = 0;
   logic        inj_sw_start = 0, inj_hw_trig = 0, inj_hw_en = 0;
   logic        reg_eoc_clr = 0, inj_eoc_clr = 0;
   logic        conv_start, conv_done = 0;
   logic [4:0]  conv_chan;
   logic [11:0] conv_result = '0;
   logic [15:0] reg_data;
   logic [63:0] inj_data;
   logic        reg_eoc, inj_eoc;

   int ntests = 0, nfail = 0, nlog = 0;
   logic [4:0] clog [0:255];
   bit finished = 0;

   always #2 clk = ~clk;

   adc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_chan_tbl(reg_tbl), .reg_len(reg_len),
      .inj_chan_tbl(inj_tbl), .inj_len(inj_len), .scan_en(scan_en),
      .cont_en(cont_en), .disc_en(disc_en), .disc_chunk(disc_chunk),
      .align_left(align_left), .reg_sw_start(reg_sw_start),
      .reg_hw_trig(reg_hw_trig), .reg_hw_en(reg_hw_en),
      .inj_sw_start(inj_sw_start), .inj_hw_trig(inj_hw_trig),
      .inj_hw_en(inj_hw_en), .reg_eoc_clr(reg_eoc_clr),
      .inj_eoc_clr(inj_eoc_clr), .conv_start(conv_start),
      .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_result(conv_result), .reg_data(reg_data), .inj_data(inj_data),
      .reg_eoc(reg_eoc), .inj_eoc(inj_eoc));

   function automatic logic [11:0] conv_val(input logic [4:0] ch);
      return 12'h800 | (12'(ch) * 12'd37);
   endfunction

   // converter model: logs every start, answers LAT cycles later
   initial begin
      int cnt = 0;
      logic [4:0] cur = '0;
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               conv_done   = 1'b1;
               conv_result = conv_val(cur);
            end
         end
         if (conv_start) begin
            cur = conv_chan;
            if (nlog < 256) clog[nlog] = conv_chan;
            nlog++;
            cnt = LAT;
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_seq(input string req, input int base, input int n,
                          input int e0 = 0, input int e1 = 0, input int e2 = 0,
                          input int e3 = 0, input int e4 = 0);
      int exp [5];
      int bad = -1;
      exp = '{e0, e1, e2, e3, e4};
      ntests++;
      if (nlog - base != n) begin
         nfail++;
         $display("FAIL %s conversions actual=%0d expected=%0d", req, nlog - base, n);
      end else begin
         for (int i = 0; i < n; i++)
            if (bad < 0 && int'(clog[base+i]) != exp[i]) bad = i;
         if (bad >= 0) begin
            nfail++;
            $display("FAIL %s entry %0d actual=%0d expected=%0d",
                     req, bad, clog[base+bad], exp[bad]);
         end
      end
   endtask

   task automatic settle();
      int last;
      forever begin
         last = nlog;
         repeat (30) @(negedge clk);
         if (nlog == last) break;
      end
   endtask

   task automatic set_reg(input int slot, input int ch);
      reg_tbl[slot*5 +: 5] = 5'(ch);
   endtask

   task automatic set_inj(input int slot, input int ch);
      inj_tbl[slot*5 +: 5] = 5'(ch);
   endtask

   task automatic reg_go();
      reg_sw_start = 1'b1;
      @(negedge clk);
      reg_sw_start = 1'b0;
   endtask

   task automatic inj_go();
      inj_sw_start = 1'b1;
      @(negedge clk);
      inj_sw_start = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 conv_start", 64'(conv_start), 0);
      chk("R1 reg_data", 64'(reg_data), 0);
      chk("R1 inj_data", inj_data, 0);
      chk("R1 flags", 64'({reg_eoc, inj_eoc}), 0);
   endtask

   task automatic t_single();
      int b = nlog;
      scan_en = 0; reg_len = 4'd3;
      set_reg(0, 7); set_reg(1, 9);
      reg_go(); settle();
      chk_seq("R2 single slot0", b, 1, 7);
      chk("R9 right align", 64'(reg_data), 64'({4'h0, conv_val(5'd7)}));
      chk("R10 reg_eoc set", 64'(reg_eoc), 1);
   endtask

   task automatic t_scan();
      int b = nlog;
      scan_en = 1; reg_len = 4'd3;
      set_reg(0, 3); set_reg(1, 16); set_reg(2, 17); set_reg(3, 9);
      reg_go();
      repeat (8) @(negedge clk);
      reg_go();   // R11: retrigger while running is ignored
      settle();
      chk_seq("R3 R7 R11 scan order", b, 4, 3, 16, 17, 9);
      chk("R3 last result", 64'(reg_data), 64'({4'h0, conv_val(5'd9)}));
   endtask

   task automatic t_left();
      int b = nlog;
      scan_en = 0; align_left = 1; set_reg(0, 6);
      reg_go(); settle();
      chk_seq("R9 left conv", b, 1, 6);
      chk("R9 left align", 64'(reg_data), 64'({conv_val(5'd6), 4'h0}));
      align_left = 0;
   endtask

   task automatic t_eoc_clear();
      reg_eoc_clr = 1; @(negedge clk); reg_eoc_clr = 0;
      chk("R10 reg_eoc cleared", 64'(reg_eoc), 0);
   endtask

   task automatic t_cont();
      int b = nlog, n, bad = 0;
      scan_en = 1; cont_en = 1; reg_len = 4'd1;
      set_reg(0, 2); set_reg(1, 5);
      reg_go();
      while (nlog - b < 5) @(negedge clk);
      cont_en = 0;
      settle();
      n = nlog - b;
      for (int i = 0; i < n; i++)
         if (clog[b+i] != ((i % 2 == 0) ? 5'd2 : 5'd5)) bad++;
      chk("R4 wrap pattern", 64'(bad), 0);
      chk("R4 stops after last slot", 64'((n >= 6) && (n % 2 == 0)), 1);
   endtask

   task automatic t_disc();
      int b;
      scan_en = 1; disc_en = 1; cont_en = 1; disc_chunk = 3'd1; reg_len = 4'd4;
      for (int i = 0; i < 5; i++) set_reg(i, i + 1);
      b = nlog; reg_go(); settle();
      chk_seq("R5 chunk1", b, 2, 1, 2);
      b = nlog; reg_go(); settle();
      chk_seq("R5 chunk2", b, 2, 3, 4);
      b = nlog; reg_go(); settle();
      chk_seq("R5 tail chunk", b, 1, 5);
      b = nlog; reg_go(); settle();
      chk_seq("R5 wrap", b, 2, 1, 2);
      disc_en = 0; cont_en = 0;
      b = nlog; reg_go(); settle();   // state after disc: resumes at slot 2
      chk_seq("R5 resume slot", b, 3, 3, 4, 5);
   endtask

   task automatic t_inj();
      int b = nlog;
      inj_len = 2'd2;
      set_inj(0, 10); set_inj(1, 11); set_inj(2, 12); set_inj(3, 13);
      inj_go(); settle();
      chk_seq("R6 inj order", b, 3, 10, 11, 12);
      chk("R6 inj slot0", 64'(inj_data[15:0]), 64'({4'h0, conv_val(5'd10)}));
      chk("R6 inj slot2", 64'(inj_data[47:32]), 64'({4'h0, conv_val(5'd12)}));
      chk("R6 unused slot3", 64'(inj_data[63:48]), 0);
      chk("R10 inj_eoc", 64'(inj_eoc), 1);
      inj_eoc_clr = 1; @(negedge clk); inj_eoc_clr = 0;
      chk("R10 inj_eoc cleared", 64'(inj_eoc), 0);
   endtask

   task automatic t_preempt();
      int b = nlog;
      scan_en = 1; reg_len = 4'd3; inj_len = 2'd0;
      for (int i = 0; i < 4; i++) set_reg(i, i);
      set_inj(0, 15);
      reg_go();
      while (nlog == b) @(negedge clk);
      inj_go();
      settle();
      chk_seq("R8 preempt order", b, 5, 0, 15, 1, 2, 3);
      chk("R8 reg_data kept", 64'(reg_data), 64'({4'h0, conv_val(5'd3)}));
      chk("R8 inj result", 64'(inj_data[15:0]), 64'({4'h0, conv_val(5'd15)}));
   endtask

   task automatic t_hw();
      int b = nlog;
      scan_en = 0; set_reg(0, 4); reg_hw_en = 0;
      reg_hw_trig = 1; @(negedge clk); reg_hw_trig = 0;
      settle();
      chk_seq("R11 hw gated off", b, 0);
      reg_hw_en = 1;
      reg_hw_trig = 1; @(negedge clk); reg_hw_trig = 0;
      settle();
      chk_seq("R11 hw enabled", b, 1, 4);
      b = nlog; inj_hw_en = 1; inj_len = 2'd0; set_inj(0, 8);
      inj_hw_trig = 1; @(negedge clk); inj_hw_trig = 0;
      settle();
      chk_seq("R11 inj hw", b, 1, 8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_scan();
      t_left();
      t_eoc_clear();
      t_cont();
      t_disc();
      t_inj();
      t_preempt();
      t_hw();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         ntests++; nfail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end
endmodule